// File: doc/BRIEF.md
# Synchronization Unit Configuration and Access Decoder

This block is the front end of an inter-thread synchronization unit. It keeps two 64-bit address-map registers, reached through a small tag window. These registers set where the storage window sits, how large it is, whether it answers at all, and how far apart the cells are spaced. Each storage access that arrives is decoded from its address into a cell number and an access view. The request is then sent on to the cell datapaths over a select channel, or answered locally.

Some requests never reach a cell. These are accesses that miss the window, accesses narrower than 4 bytes, accesses to the status view and accesses to an unused view code. The block answers each of them on a local response channel. It also owns the unit's status register, which holds three sticky error flags and a 3-bit block-grain field. Every request accepted on the storage channel produces exactly one beat on exactly one of the two output channels.

The storage input and both output channels use valid/ready. A beat moves when valid and ready are both high on a clock edge. A source holds its beat unchanged while valid is high and ready is low. The block raises `st_ready` only when neither output register would be left holding a beat that cannot move, so back-pressure on either output stalls the whole input. The tag window and the error-report pins are plain control signals.

Top module: `sync_unit_cfg`

## Requirements
- R1: Tag-window register index is `tag_addr` shifted right by 3. Index 0 is map register A and index 1 is map register B. A read returns the register on `tag_rdata` with `tag_rvalid` one cycle later. Any other index reads as zero, and writes to it change nothing.
- R2: A write to map register A updates only bits 31:10 (window base) and bit 0 (window enable). All other bits keep their old value.
- R3: A write to map register B updates only bits 16:10 (address mask) and bits 2:0 (grain). All other bits keep their old value, including the read-only cell-count field at bits 25:20.
- R4: After reset, register A is zero and register B holds mask value 0xC00 plus the total cell count in bits 25:20. The status register is zero and the window is disabled.
- R5: A storage access hits only while register A bit 0 is set and base <= address < base + size, with base = A[31:10] << 10. A miss is answered locally with code 2 (no hit) and data 0, and it changes no state.
- R6: Window size is 0x400 plus the value of B bits 16:10 taken in place. The size after reset is 0x1000. A register B write changes the size only if the new size is a power of two; otherwise the previous size stays.
- R7: Address bits 6:3 are the view code. Views 0 to 5 on a hit of 4 or 8 bytes are forwarded on the cell channel with the view code, the write flag and the write data.
- R8: The cell index is (address − base) shifted right by 7 + B[2:0]. An index at or above the total cell count is clamped to the last cell. `cel_fifo` is high when the index is below the FIFO-cell count.
- R9: A hit with `st_size` 0 (1 byte) or 1 (2 bytes) sets status bit 2. It is answered locally with code 1 (bus error) and data 0, and it is not forwarded.
- R10: View 15 reads return the status register, zero-extended, with code 0. View 15 writes clear each of status bits 2:0 that has a 1 in the data and load status bits 10:8 from data bits 10:8. All other status bits read zero.
- R11: Views 6 to 14 read as all ones with code 0. Writes to them have no effect and answer with code 0 and data 0.
- R12: Each accepted request yields one beat, on exactly one output, one cycle later. An output beat stays unchanged while it is valid and not ready. `st_ready` is low whenever an output holds a beat that is not being taken.
- R13: A 1 on `err_rpt[0]` or `err_rpt[1]` sets status bit 0 or bit 1. A set in the same cycle as a clear of that bit wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tag_valid | input | 1 | Tag-window access strobe |
| tag_we | input | 1 | Tag-window write when high, read when low |
| tag_addr | input | TAG_AW | Tag-window byte address |
| tag_wdata | input | DATA_W | Tag-window write data |
| tag_rvalid | output | 1 | Tag read data valid, one cycle after the read |
| tag_rdata | output | DATA_W | Tag read data |
| st_valid | input | 1 | Storage request valid |
| st_ready | output | 1 | Storage request ready |
| st_we | input | 1 | Storage request is a write |
| st_size | input | 2 | Access size: 0=1 B, 1=2 B, 2=4 B, 3=8 B |
| st_addr | input | ADDR_W | Storage request address |
| st_wdata | input | DATA_W | Storage write data |
| cel_valid | output | 1 | Cell select beat valid |
| cel_ready | input | 1 | Cell select beat ready |
| cel_idx | output | IDX_W | Clamped cell index |
| cel_view | output | 4 | View code 0 to 5 |
| cel_we | output | 1 | Forwarded write flag |
| cel_wdata | output | DATA_W | Forwarded write data |
| cel_fifo | output | 1 | Selected cell is a FIFO cell |
| loc_valid | output | 1 | Local response valid |
| loc_ready | input | 1 | Local response ready |
| loc_resp | output | 2 | 0 ok, 1 bus error, 2 no hit |
| loc_rdata | output | DATA_W | Local response data |
| err_rpt | input | 2 | Error set pulses from the cells for status bits 1:0 |

## Verification
The bench builds the block with three FIFO cells and two semaphore cells. With five cells, a 4 KiB window with a 128-byte stride already holds addresses whose raw index lies far past the last cell, so clamping shows up under ordinary random traffic. The boundary between FIFO and semaphore cells also falls inside the reachable index range. The small count also makes the cell-count field of map register B easy to check after reset. Grain changes, a window shrunk below its default and a rejected non-power-of-two size are driven as directed cases before the random mix.

// File: rtl/sync_cfg_pkg.sv
package sync_cfg_pkg;

  // local response codes
  typedef enum logic [1:0] {
    RESP_OK     = 2'd0,
    RESP_BUSERR = 2'd1,
    RESP_NOHIT  = 2'd2
  } resp_e;

  // view codes that the decoder treats specially
  localparam logic [3:0] VIEW_LAST_CELL = 4'd5;
  localparam logic [3:0] VIEW_STATUS    = 4'd15;

  // map register write masks
  localparam logic [63:0] MAPA_WMASK = 64'h0000_0000_FFFF_FC01;
  localparam logic [63:0] MAPB_WMASK = 64'h0000_0000_0001_FC07;

  // map register B reset mask value and cell-count field position
  localparam logic [63:0] MAPB_MASK_RST = 64'h0000_0000_0000_0C00;
  localparam int unsigned COUNT_LSB     = 20;

  // stride and window geometry
  localparam int unsigned STRIDE_MIN_SH = 7;
  localparam int unsigned SIZE_W        = 18;
  localparam logic [SIZE_W-1:0] SIZE_BASE = 18'h0_0400;
  localparam logic [SIZE_W-1:0] SIZE_RST  = 18'h0_1000;

endpackage

// File: rtl/sync_tag_regs.sv
module sync_tag_regs
  import sync_cfg_pkg::*;
#(
  parameter int unsigned N_CELLS = 32,
  parameter int unsigned TAG_AW  = 6,
  parameter int unsigned DATA_W  = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tag_valid,
  input  logic                 tag_we,
  input  logic [TAG_AW-1:0]    tag_addr,
  input  logic [DATA_W-1:0]    tag_wdata,
  output logic                 tag_rvalid,
  output logic [DATA_W-1:0]    tag_rdata,
  output logic                 win_en,
  output logic [31:0]          win_base,
  output logic [SIZE_W-1:0]    win_size,
  output logic [2:0]           grain
);
  localparam int unsigned IW = TAG_AW - 3;
  localparam logic [63:0] MAPB_RST = MAPB_MASK_RST | (64'(N_CELLS) << COUNT_LSB);

  logic [63:0]       map_a_q, map_b_q, map_b_next;
  logic [SIZE_W-1:0] size_q, size_cand;
  logic [IW-1:0]     tidx;
  logic              wr_a, wr_b;
  logic              unused_tag;

  assign tidx       = tag_addr[TAG_AW-1:3];
  assign unused_tag = ^{tag_addr[2:0]};
  assign wr_a = tag_valid && tag_we && (tidx == IW'(0));
  assign wr_b = tag_valid && tag_we && (tidx == IW'(1));

  assign map_b_next = (64'(tag_wdata) & MAPB_WMASK) | (map_b_q & ~MAPB_WMASK);
  assign size_cand  = SIZE_BASE + {1'b0, map_b_next[16:10], 10'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_a_q <= '0;
      map_b_q <= MAPB_RST;
      size_q  <= SIZE_RST;
    end else begin
      if (wr_a)
        map_a_q <= (64'(tag_wdata) & MAPA_WMASK) | (map_a_q & ~MAPA_WMASK);
      if (wr_b) begin
        map_b_q <= map_b_next;
        if ((size_cand & (size_cand - 1'b1)) == '0)
          size_q <= size_cand;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_rvalid <= 1'b0;
      tag_rdata  <= '0;
    end else begin
      tag_rvalid <= tag_valid && !tag_we;
      if (tag_valid && !tag_we) begin
        if (tidx == IW'(0))      tag_rdata <= DATA_W'(map_a_q);
        else if (tidx == IW'(1)) tag_rdata <= DATA_W'(map_b_q);
        else                     tag_rdata <= '0;
      end
    end
  end

  assign win_en   = map_a_q[0];
  assign win_base = {map_a_q[31:10], 10'b0};
  assign win_size = size_q;
  assign grain    = map_b_q[2:0];

endmodule

// File: rtl/sync_status_reg.sv
module sync_status_reg #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              narrow_set,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rpt_set,
  output logic [DATA_W-1:0] status
);
  logic [2:0] err_q, clr, setv;
  logic [2:0] bgrain_q;
  logic       unused_wd;

  assign clr       = wr_en ? wr_data[2:0] : 3'b000;
  assign setv      = {narrow_set, rpt_set};
  assign unused_wd = ^{wr_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q    <= '0;
      bgrain_q <= '0;
    end else begin
      err_q <= (err_q & ~clr) | setv;
      if (wr_en) bgrain_q <= wr_data[10:8];
    end
  end

  assign status = DATA_W'({bgrain_q, 5'b0, err_q});

endmodule

// File: rtl/sync_access_decode.sv
module sync_access_decode
  import sync_cfg_pkg::*;
#(
  parameter int unsigned N_FIFO  = 16,
  parameter int unsigned N_CELLS = 32,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned IDX_W   = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size_code,
  input  logic              win_en,
  input  logic [31:0]       win_base,
  input  logic [SIZE_W-1:0] win_size,
  input  logic [2:0]        grain,
  output logic              hit,
  output logic              narrow,
  output logic [3:0]        view,
  output logic [IDX_W-1:0]  idx,
  output logic              is_fifo,
  output logic              to_cell
);
  localparam logic [ADDR_W-1:0] LAST_RAW = ADDR_W'(N_CELLS - 1);

  logic [ADDR_W-1:0] base_ext, offset, raw;
  logic [3:0]        sh;

  assign base_ext = ADDR_W'(win_base);
  assign offset   = addr - base_ext;
  assign hit      = win_en && (addr >= base_ext) && (offset < ADDR_W'(win_size));
  assign narrow   = !size_code[1];
  assign view     = addr[6:3];
  assign sh       = 4'(STRIDE_MIN_SH) + {1'b0, grain};
  assign raw      = offset >> sh;

  // clamp: a full power-of-two index range needs only the upper bits checked
  generate
    if ((1 << IDX_W) == N_CELLS) begin : g_pow2
      assign idx = (raw[ADDR_W-1:IDX_W] != '0) ? IDX_W'(N_CELLS - 1) : raw[IDX_W-1:0];
    end else begin : g_cmp
      assign idx = (raw > LAST_RAW) ? IDX_W'(N_CELLS - 1) : raw[IDX_W-1:0];
    end
  endgenerate

  assign is_fifo = (32'(idx) < N_FIFO);
  assign to_cell = hit && !narrow && (view <= VIEW_LAST_CELL);

endmodule

// File: rtl/sync_unit_cfg.sv
module sync_unit_cfg
  import sync_cfg_pkg::*;
#(
  parameter int unsigned N_FIFO = 16,
  parameter int unsigned N_SEM  = 16,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned TAG_AW = 6,
  localparam int unsigned N_CELLS = N_FIFO + N_SEM,
  localparam int unsigned IDX_W   = (N_CELLS > 1) ? $clog2(N_CELLS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tag_valid,
  input  logic              tag_we,
  input  logic [TAG_AW-1:0] tag_addr,
  input  logic [DATA_W-1:0] tag_wdata,
  output logic              tag_rvalid,
  output logic [DATA_W-1:0] tag_rdata,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic              st_we,
  input  logic [1:0]        st_size,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_wdata,
  output logic              cel_valid,
  input  logic              cel_ready,
  output logic [IDX_W-1:0]  cel_idx,
  output logic [3:0]        cel_view,
  output logic              cel_we,
  output logic [DATA_W-1:0] cel_wdata,
  output logic              cel_fifo,
  output logic              loc_valid,
  input  logic              loc_ready,
  output logic [1:0]        loc_resp,
  output logic [DATA_W-1:0] loc_rdata,
  input  logic [1:0]        err_rpt
);
  logic              win_en;
  logic [31:0]       win_base;
  logic [SIZE_W-1:0] win_size;
  logic [2:0]        grain;
  logic              hit, narrow, is_fifo, to_cell;
  logic [3:0]        view;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] status;
  logic              accept, stat_wr, narrow_set;
  resp_e             resp_d;
  logic [DATA_W-1:0] rdata_d;

  sync_tag_regs #(.N_CELLS(N_CELLS), .TAG_AW(TAG_AW), .DATA_W(DATA_W)) u_tag (
    .clk(clk), .rst_n(rst_n),
    .tag_valid(tag_valid), .tag_we(tag_we), .tag_addr(tag_addr), .tag_wdata(tag_wdata),
    .tag_rvalid(tag_rvalid), .tag_rdata(tag_rdata),
    .win_en(win_en), .win_base(win_base), .win_size(win_size), .grain(grain)
  );

  sync_access_decode #(.N_FIFO(N_FIFO), .N_CELLS(N_CELLS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .addr(st_addr), .size_code(st_size),
    .win_en(win_en), .win_base(win_base), .win_size(win_size), .grain(grain),
    .hit(hit), .narrow(narrow), .view(view), .idx(idx), .is_fifo(is_fifo), .to_cell(to_cell)
  );

  assign st_ready   = (!cel_valid || cel_ready) && (!loc_valid || loc_ready);
  assign accept     = st_valid && st_ready;
  assign narrow_set = accept && hit && narrow;
  assign stat_wr    = accept && hit && !narrow && (view == VIEW_STATUS) && st_we;

  sync_status_reg #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst_n(rst_n),
    .narrow_set(narrow_set), .wr_en(stat_wr), .wr_data(st_wdata),
    .rpt_set(err_rpt), .status(status)
  );

  // local answer for everything that does not reach a cell
  always_comb begin
    resp_d  = RESP_OK;
    rdata_d = '0;
    if (!hit) begin
      resp_d = RESP_NOHIT;
    end else if (narrow) begin
      resp_d = RESP_BUSERR;
    end else if (view == VIEW_STATUS) begin
      rdata_d = st_we ? '0 : status;
    end else begin
      rdata_d = st_we ? '0 : '1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cel_valid <= 1'b0;
      cel_idx   <= '0;
      cel_view  <= '0;
      cel_we    <= 1'b0;
      cel_wdata <= '0;
      cel_fifo  <= 1'b0;
    end else if (accept && to_cell) begin
      cel_valid <= 1'b1;
      cel_idx   <= idx;
      cel_view  <= view;
      cel_we    <= st_we;
      cel_wdata <= st_wdata;
      cel_fifo  <= is_fifo;
    end else if (cel_ready) begin
      cel_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loc_valid <= 1'b0;
      loc_resp  <= RESP_OK;
      loc_rdata <= '0;
    end else if (accept && !to_cell) begin
      loc_valid <= 1'b1;
      loc_resp  <= resp_d;
      loc_rdata <= rdata_d;
    end else if (loc_ready) begin
      loc_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/sync_unit_cfg_chk.sv
module sync_unit_cfg_chk #(
  parameter int unsigned N_CELLS = 32,
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned DATA_W  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_valid,
  input logic              st_ready,
  input logic              tag_valid,
  input logic              tag_we,
  input logic              tag_rvalid,
  input logic              cel_valid,
  input logic              cel_ready,
  input logic [IDX_W-1:0]  cel_idx,
  input logic [3:0]        cel_view,
  input logic              loc_valid,
  input logic              loc_ready,
  input logic [1:0]        loc_resp,
  input logic [DATA_W-1:0] loc_rdata,
  input logic [DATA_W-1:0] status
);
  // R1: a tag read is answered on the next cycle
  p_tag_rvalid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_valid && !tag_we) |=> tag_rvalid);

  // R8: forwarded index never leaves the implemented cell range
  p_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cel_valid |-> (32'(cel_idx) < N_CELLS));

  // R7: only views 0..5 travel to the cells
  p_cell_view_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cel_valid |-> (cel_view <= 4'd5));

  // R9: a bus-error answer implies the narrow-access flag is set
  p_buserr_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_valid && loc_resp == 2'd1) |-> status[2]);

  // R12: one accepted request gives a beat on exactly one output
  p_one_dest_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready) |=> (cel_valid ^ loc_valid));

  // R12: stalled beats hold still
  p_cel_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cel_valid && !cel_ready) |=> (cel_valid && $stable(cel_idx) && $stable(cel_view)));

  p_loc_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_valid && !loc_ready) |=> (loc_valid && $stable(loc_resp) && $stable(loc_rdata)));

  // R12: no acceptance while a stalled beat is held
  p_ready_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((cel_valid && !cel_ready) || (loc_valid && !loc_ready)) |-> !st_ready);

endmodule

bind sync_unit_cfg sync_unit_cfg_chk #(.N_CELLS(N_CELLS), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
  .tag_valid(tag_valid), .tag_we(tag_we), .tag_rvalid(tag_rvalid),
  .cel_valid(cel_valid), .cel_ready(cel_ready), .cel_idx(cel_idx), .cel_view(cel_view),
  .loc_valid(loc_valid), .loc_ready(loc_ready), .loc_resp(loc_resp), .loc_rdata(loc_rdata),
  .status(status)
);

// File: tb/sync_unit_cfg_bench.sv
module sync_unit_cfg_bench;
  localparam int NF = 3;
  localparam int NS = 2;
  localparam int NC = NF + NS;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        tag_valid = 0, tag_we = 0;
  logic [5:0]  tag_addr = '0;
  logic [63:0] tag_wdata = '0;
  logic        tag_rvalid;
  logic [63:0] tag_rdata;
  logic        st_valid = 0, st_ready, st_we = 0;
  logic [1:0]  st_size = 2'd3;
  logic [31:0] st_addr = '0;
  logic [63:0] st_wdata = '0;
  logic        cel_valid, cel_ready = 1, cel_we, cel_fifo;
  logic [IW-1:0] cel_idx;
  logic [3:0]  cel_view;
  logic [63:0] cel_wdata;
  logic        loc_valid, loc_ready = 1;
  logic [1:0]  loc_resp;
  logic [63:0] loc_rdata;
  logic [1:0]  err_rpt = '0;

  sync_unit_cfg #(.N_FIFO(NF), .N_SEM(NS)) u_sync_unit_cfg (
    .clk(clk), .rst_n(rst_n),
    .tag_valid(tag_valid), .tag_we(tag_we), .tag_addr(tag_addr), .tag_wdata(tag_wdata),
    .tag_rvalid(tag_rvalid), .tag_rdata(tag_rdata),
    .st_valid(st_valid), .st_ready(st_ready), .st_we(st_we), .st_size(st_size),
    .st_addr(st_addr), .st_wdata(st_wdata),
    .cel_valid(cel_valid), .cel_ready(cel_ready), .cel_idx(cel_idx), .cel_view(cel_view),
    .cel_we(cel_we), .cel_wdata(cel_wdata), .cel_fifo(cel_fifo),
    .loc_valid(loc_valid), .loc_ready(loc_ready), .loc_resp(loc_resp), .loc_rdata(loc_rdata),
    .err_rpt(err_rpt)
  );

  int checks = 0;
  int errors = 0;

  // reference model
  logic [63:0] m_a, m_b, m_icr;
  int unsigned m_size;

  function automatic logic pow2(int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

  function automatic logic exp_hit(logic [31:0] a);
    logic [31:0] base = {m_a[31:10], 10'b0};
    return m_a[0] && (a >= base) && ((a - base) < m_size);
  endfunction

  function automatic int exp_idx(logic [31:0] a);
    int unsigned r = (a - {m_a[31:10], 10'b0}) >> (7 + m_b[2:0]);
    return (r >= NC) ? NC - 1 : int'(r);
  endfunction

  task automatic chk(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tag_wr(input int idx, input logic [63:0] d);
    @(negedge clk);
    tag_valid = 1; tag_we = 1; tag_addr = 6'(idx << 3); tag_wdata = d;
    @(negedge clk);
    tag_valid = 0; tag_we = 0;
    if (idx == 0) m_a = (d & 64'hFFFF_FC01) | (m_a & ~64'hFFFF_FC01);
    else if (idx == 1) begin
      int unsigned cand;
      m_b = (d & 64'h1FC07) | (m_b & ~64'h1FC07);
      cand = 32'h400 + int'(m_b[16:10]) * 1024;
      if (pow2(cand)) m_size = cand;
    end
  endtask

  task automatic tag_rd(input int idx, input logic [63:0] exp, input string req);
    @(negedge clk);
    tag_valid = 1; tag_we = 0; tag_addr = 6'(idx << 3);
    @(negedge clk);
    tag_valid = 0;
    chk(tag_rvalid && tag_rdata == exp, req, {63'b0, tag_rvalid, tag_rdata}, {64'b1, exp});
  endtask

  task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic we,
                        input logic [63:0] wd, input logic [1:0] rpt);
    logic h = exp_hit(a);
    logic nar = (sz < 2);
    logic [3:0] v = a[6:3];
    string req;
    logic [127:0] act, exp;
    @(negedge clk);
    st_valid = 1; st_addr = a; st_size = sz; st_we = we; st_wdata = wd; err_rpt = rpt;
    chk(st_ready, "R12", {127'b0, st_ready}, 128'd1);
    @(negedge clk);
    st_valid = 0; err_rpt = '0;
    if (h && !nar && v <= 5) begin
      int ix = exp_idx(a);
      req = "R7/R8";
      act = {cel_valid, loc_valid, 3'(cel_idx), cel_view, cel_we, cel_fifo, cel_wdata};
      exp = {1'b1, 1'b0, 3'(ix), v, we, (ix < NF), wd};
    end else begin
      logic [1:0] r; logic [63:0] d;
      if (!h) begin r = 2; d = 0; req = "R5"; end
      else if (nar) begin r = 1; d = 0; req = "R9"; end
      else if (v == 15) begin r = 0; d = we ? 64'd0 : m_icr; req = "R10"; end
      else begin r = 0; d = we ? 64'd0 : '1; req = "R11"; end
      act = {cel_valid, loc_valid, loc_resp, loc_rdata};
      exp = {1'b0, 1'b1, r, d};
    end
    chk(act == exp, req, act, exp);
    if (h && nar) m_icr[2] = 1'b1;
    if (h && !nar && v == 15 && we) begin
      m_icr[2:0] = m_icr[2:0] & ~wd[2:0];
      m_icr[10:8] = wd[10:8];
    end
    m_icr[1:0] = m_icr[1:0] | rpt;
  endtask

  task automatic status_rd(input string req);
    access({m_a[31:10], 10'b0} + 32'h78, 2'd3, 1'b0, 64'd0, 2'b00);
    checks++;
    if (loc_rdata != m_icr) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, loc_rdata, m_icr);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  localparam logic [31:0] BASE = 32'h0004_0000;

  initial begin
    logic [31:0] held;
    void'($urandom(32'd1234));
    m_a = 0; m_b = 64'hC00 | (64'(NC) << 20); m_icr = 0; m_size = 32'h1000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R4: reset values
    chk(!cel_valid && !loc_valid && st_ready, "R4", {cel_valid, loc_valid, st_ready}, 3'b001);
    tag_rd(0, 64'd0, "R4");
    tag_rd(1, 64'h0050_0C00, "R4");
    // R5: disabled window misses
    access(32'h0, 2'd3, 1'b0, 64'd0, 2'b00);
    // R2: write mask of register A
    tag_wr(0, '1);
    tag_rd(0, 64'hFFFF_FC01, "R2");
    tag_wr(0, {32'hFFFF_FFFF, BASE | 32'h3FF});
    tag_rd(0, 64'(BASE) | 64'h1, "R2");
    // R1: unimplemented indices
    tag_rd(2, 64'd0, "R1");
    tag_wr(3, '1);
    tag_rd(0, 64'(BASE) | 64'h1, "R1");
    tag_rd(1, 64'h0050_0C00, "R1");
    // R3: register B mask, count field read-only
    tag_wr(1, '1);
    tag_rd(1, 64'h0051_FC07, "R3");
    // R6: 128 KiB window with grain 7 (clamped index)
    access(BASE + 32'h1_8000, 2'd2, 1'b1, 64'hA5, 2'b00);
    tag_wr(1, 64'h800); // size 0xC00 rejected
    access(BASE + 32'h1_0000, 2'd3, 1'b0, 64'd0, 2'b00);
    tag_wr(1, 64'h400); // size 0x800
    access(BASE + 32'h900, 2'd3, 1'b0, 64'd0, 2'b00);
    access(BASE + 32'h780, 2'd3, 1'b0, 64'd0, 2'b00);
    access(BASE - 32'h8, 2'd3, 1'b0, 64'd0, 2'b00);
    tag_wr(1, 64'hC00);
    // R7/R8: every cell view, FIFO/semaphore boundary
    for (int v = 0; v < 6; v++)
      access(BASE + 32'(v * 128) + 32'(v << 3), 2'd3, v[0], 64'h1234_0000 + 64'(v), 2'b00);
    tag_wr(1, 64'hC02); // grain 2, stride 512
    access(BASE + 32'h400 + 32'h10, 2'd3, 1'b1, 64'h77, 2'b00);
    access(BASE + 32'h600, 2'd2, 1'b0, 64'd0, 2'b00);
    tag_wr(1, 64'hC00);
    // R9/R10: narrow error, status write one-to-clear
    access(BASE + 32'h8, 2'd0, 1'b0, 64'd0, 2'b00);
    access(BASE + 32'h8, 2'd1, 1'b1, 64'd0, 2'b00);
    status_rd("R9");
    access(BASE + 32'h78, 2'd3, 1'b1, 64'hFFFF_F504, 2'b00);
    status_rd("R10");
    // R11: unused view write has no effect, read is all ones
    access(BASE + 32'h38, 2'd3, 1'b1, '1, 2'b00);
    access(BASE + 32'h50, 2'd3, 1'b0, 64'd0, 2'b00);
    status_rd("R11");
    // R13: report set, and set winning over clear
    access(BASE + 32'h0, 2'd3, 1'b0, 64'd0, 2'b10);
    status_rd("R13");
    access(BASE + 32'h78, 2'd3, 1'b1, 64'h3, 2'b01);
    status_rd("R13");
    // R12: back-pressure on the cell channel
    @(negedge clk);
    cel_ready = 0;
    st_valid = 1; st_addr = BASE + 32'h100; st_size = 2'd3; st_we = 0;
    @(negedge clk);
    st_addr = BASE + 32'h80;
    held = 32'(cel_idx);
    repeat (2) begin
      @(negedge clk);
      chk(cel_valid && !st_ready && cel_idx == 3'd2, "R12",
          {cel_valid, st_ready, cel_idx}, {1'b1, 1'b0, 3'd2});
    end
    cel_ready = 1;
    @(negedge clk);
    st_valid = 0;
    chk(cel_valid && cel_idx == 3'd1 && held == 32'd2, "R12", {cel_valid, cel_idx}, {1'b1, 3'd1});
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a = BASE - 32'h100 + ($urandom % 32'h1300);
      logic [1:0] sz = 2'($urandom);
      logic we = 1'($urandom);
      logic [63:0] wd = {$urandom, $urandom};
      logic [1:0] rpt = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
      if (($urandom % 25) == 0) tag_wr(1, 64'hC00 | 64'($urandom % 4));
      if ((a[6:3] == 4'd15) && ($urandom % 2 == 0)) sz = 2'd3;
      access(a, sz, we, wd, rpt);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule